// File: doc/BRIEF.md
# Dual-View General Register File

This block holds the general-purpose integer state of a processor core: thirty-one 64-bit entries behind two combinational read ports and one clocked write port. Every port carries a size flag. When the flag selects the full view, the port moves all 64 bits. When it selects the half view, the port works on the low 32 bits of the same entry. A half-view read returns those bits with zeros above them. A half-view write stores the low 32 bits of the data and clears the upper 32 bits of the entry, so a 32-bit result never leaves stale data in the upper half.

Index 31 has no storage behind it. It reads as zero on both ports, and a write to it is dropped. A read that addresses the entry being written in the same cycle sees the new value. The write-side shaping and then the read-side view are applied to that value. A synchronous active-high reset clears every entry.

Top module: `dvrf_top`

## Requirements
- R1: A write with `wr_en`=1 and `wr_wide`=1 to index 0..30 stores all 64 bits of `wr_data`. From the next cycle on, a read of that index with the wide flag set returns those 64 bits.
- R2: A read with the wide flag at 0 returns bits [31:0] of the entry in bits [31:0] of the read bus and zero in bits [63:32].
- R3: A write with `wr_en`=1 and `wr_wide`=0 stores `wr_data[31:0]` in bits [31:0] of the entry and sets bits [63:32] to zero.
- R4: A read of index 31 returns zero on either port, whatever the view.
- R5: A write to index 31 changes no entry.
- R6: When `wr_en`=1, `rst`=0 and a port's index equals `wr_idx` (an index other than 31), that port returns the shaped write data in the same cycle, with its own view applied on top.
- R7: While `rst`=1 at a rising edge, all 31 entries become zero and any write in that cycle is dropped. While `rst` is high, no bypass takes place.
- R8: The two read ports are independent. Each returns its own index and view in the same cycle.
- R9: With `wr_en`=0, no entry changes at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable, sampled at the rising edge |
| wr_idx | input | 5 | Write index (31 = discard) |
| wr_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write with the upper half cleared |
| wr_data | input | 64 | Write data |
| ra_idx | input | 5 | Read port A index |
| ra_wide | input | 1 | Read port A view: 1 = 64-bit, 0 = low 32 bits zero-extended |
| ra_data | output | 64 | Read port A data (combinational) |
| rb_idx | input | 5 | Read port B index |
| rb_wide | input | 1 | Read port B view |
| rb_data | output | 64 | Read port B data (combinational) |

## Verification
The assertions check these properties on every cycle:
- a half-view read always has a zero upper half;
- index 31 always reads as zero;
- a same-cycle bypass with both views wide returns the write data;
- a written entry read back one cycle later holds the full or shaped value;
- reads just after reset return zero.

Some behaviours need history longer than one cycle, so only the bench scenarios show them. These are that a write to index 31 or a write with the enable low leaves all earlier contents in place, and that reset clears every one of the 31 entries. The bench uses a random mix of views, indices and bypass collisions, checked against a reference model.

// File: rtl/dvrf_pkg.sv
package dvrf_pkg;

    localparam int DATA_W   = 64;
    localparam int HALF_W   = DATA_W / 2;
    localparam int NUM_REGS = 31;
    localparam int IDX_W    = $clog2(NUM_REGS + 1);
    localparam logic [IDX_W-1:0] ZERO_IDX = IDX_W'(NUM_REGS);

    typedef enum logic {
        VIEW_HALF = 1'b0,
        VIEW_FULL = 1'b1
    } view_e;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        view_e            view;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [DATA_W-1:0] apply_view(input logic [DATA_W-1:0] d, input view_e v);
        if (v == VIEW_FULL) return d;
        return {HALF_W'(0), d[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/dvrf_wr_shape.sv
module dvrf_wr_shape
    import dvrf_pkg::*;
(
    input  logic    rst,
    input  wr_req_t req_i,
    output wr_req_t req_o
);
    always_comb begin
        req_o      = req_i;
        req_o.en   = req_i.en && !rst && (req_i.idx != ZERO_IDX);
        req_o.data = apply_view(req_i.data, req_i.view);
    end
endmodule

// File: rtl/dvrf_store.sv
module dvrf_store
    import dvrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wreq,
    output logic [DATA_W-1:0] regs_o [NUM_REGS]
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        logic hit;
        assign hit = wreq.en && (wreq.idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst)      regs_o[g] <= '0;
            else if (hit) regs_o[g] <= wreq.data;
        end
    end
endmodule

// File: rtl/dvrf_read_port.sv
module dvrf_read_port
    import dvrf_pkg::*;
(
    input  logic [DATA_W-1:0] regs_i [NUM_REGS],
    input  wr_req_t           wreq,
    input  logic [IDX_W-1:0]  idx,
    input  view_e             view,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] raw;

    always_comb begin
        raw = '0;
        if (idx != ZERO_IDX) begin
            if (wreq.en && wreq.idx == idx) raw = wreq.data;
            else                            raw = regs_i[idx];
        end
        data = apply_view(raw, view);
    end
endmodule

// File: rtl/dvrf_top.sv
module dvrf_top
    import dvrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [4:0]        wr_idx,
    input  logic              wr_wide,
    input  logic [63:0]       wr_data,
    input  logic [4:0]        ra_idx,
    input  logic              ra_wide,
    output logic [63:0]       ra_data,
    input  logic [4:0]        rb_idx,
    input  logic              rb_wide,
    output logic [63:0]       rb_data
);
    localparam int NPORTS = 2;

    wr_req_t           raw_req, shaped_req;
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic [IDX_W-1:0]  p_idx  [NPORTS];
    view_e             p_view [NPORTS];
    logic [DATA_W-1:0] p_data [NPORTS];

    assign raw_req.en   = wr_en;
    assign raw_req.idx  = wr_idx;
    assign raw_req.view = view_e'(wr_wide);
    assign raw_req.data = wr_data;

    dvrf_wr_shape u_shape (.rst(rst), .req_i(raw_req), .req_o(shaped_req));

    dvrf_store u_store (.clk(clk), .rst(rst), .wreq(shaped_req), .regs_o(regs));

    assign p_idx[0]  = ra_idx;
    assign p_view[0] = view_e'(ra_wide);
    assign p_idx[1]  = rb_idx;
    assign p_view[1] = view_e'(rb_wide);

    for (genvar p = 0; p < NPORTS; p++) begin : g_rport
        dvrf_read_port u_rp (
            .regs_i(regs), .wreq(shaped_req),
            .idx(p_idx[p]), .view(p_view[p]), .data(p_data[p])
        );
    end

    assign ra_data = p_data[0];
    assign rb_data = p_data[1];
endmodule

// File: rtl/dvrf_checker.sv
module dvrf_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic        wr_wide,
    input logic [63:0] wr_data,
    input logic [4:0]  ra_idx,
    input logic        ra_wide,
    input logic [63:0] ra_data,
    input logic [4:0]  rb_idx,
    input logic        rb_wide,
    input logic [63:0] rb_data
);
    p_half_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (!ra_wide |-> ra_data[63:32] == 32'h0) and (!rb_wide |-> rb_data[63:32] == 32'h0));

    p_idx31_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (ra_idx == 5'd31 |-> ra_data == 64'h0) and (rb_idx == 5'd31 |-> rb_data == 64'h0));

    p_bypass_full_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_wide && ra_wide && wr_idx == ra_idx && ra_idx != 5'd31) |-> ra_data == wr_data);

    p_full_write_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_wide && wr_idx != 5'd31) |=>
        (ra_idx != $past(wr_idx) || !ra_wide || (wr_en && wr_idx == ra_idx) || ra_data == $past(wr_data)));

    p_half_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_wide && wr_idx != 5'd31) |=>
        (ra_idx != $past(wr_idx) || !ra_wide || (wr_en && wr_idx == ra_idx) ||
         ra_data == {32'h0, $past(wr_data[31:0])}));

    p_after_reset_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !(wr_en && wr_idx == ra_idx)) |-> ra_data == 64'h0);
endmodule

bind dvrf_top dvrf_checker chk_i (.*);

// File: tb/dvrf_top_tb_top.sv
`timescale 1ns/1ps
module dvrf_top_tb_top;
    logic        clk = 1'b0;
    logic        rst, wr_en, wr_wide, ra_wide, rb_wide;
    logic [4:0]  wr_idx, ra_idx, rb_idx;
    logic [63:0] wr_data, ra_data, rb_data;

    int total = 0, bad = 0;
    bit done = 0;
    logic [63:0] model [31];

    always #2.5 clk = ~clk;

    dvrf_top dut_i (.*);

    function automatic logic [63:0] shape(input logic [63:0] d, input logic w);
        return w ? d : {32'h0, d[31:0]};
    endfunction

    function automatic logic [63:0] exp_read(input logic [4:0] idx, input logic w);
        logic [63:0] v;
        if (idx == 5'd31) return 64'h0;
        v = model[idx];
        if (wr_en && !rst && wr_idx == idx) v = shape(wr_data, wr_wide);
        return shape(v, w);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, check 1 ns later, model updates at posedge.
    task automatic step(input string tag, input logic r, input logic we, input logic [4:0] wi,
                        input logic ww, input logic [63:0] wd,
                        input logic [4:0] ai, input logic aw, input logic [4:0] bi, input logic bw);
        @(negedge clk);
        rst = r; wr_en = we; wr_idx = wi; wr_wide = ww; wr_data = wd;
        ra_idx = ai; ra_wide = aw; rb_idx = bi; rb_wide = bw;
        #1;
        check({tag, " portA"}, ra_data, exp_read(ai, aw));
        check({tag, " portB"}, rb_data, exp_read(bi, bw));
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 31; i++) model[i] = 64'h0;
        end else if (we && wi != 5'd31) model[wi] = shape(wd, ww);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        for (int i = 0; i < 31; i++) model[i] = 64'h0;
        rst = 1; wr_en = 0; wr_idx = 0; wr_wide = 1; wr_data = 0;
        ra_idx = 0; ra_wide = 1; rb_idx = 0; rb_wide = 1;
        // R7: reset with a write pending is dropped
        step("R7 reset", 1, 1, 5'd3, 1, 64'hDEAD_BEEF_0000_1111, 5'd3, 1, 5'd4, 1);
        step("R7 reset", 0, 0, 0, 1, 0, 5'd3, 1, 5'd4, 0);
        // R1: full write, R8: two ports read different entries
        step("R1 write", 0, 1, 5'd5, 1, 64'hA5A5_1234_5678_9ABC, 5'd0, 1, 5'd1, 1);
        step("R1 write", 0, 1, 5'd6, 1, 64'hFFFF_0000_FFFF_0001, 5'd5, 1, 5'd0, 1);
        step("R8 dual", 0, 0, 0, 1, 0, 5'd5, 1, 5'd6, 1);
        // R2: half read of a full entry
        step("R2 half read", 0, 0, 0, 1, 0, 5'd5, 0, 5'd6, 0);
        // R3: half write clears upper bits
        step("R3 half write", 0, 1, 5'd5, 0, 64'h7777_7777_0000_00AB, 5'd5, 1, 5'd6, 1);
        step("R3 readback", 0, 0, 0, 1, 0, 5'd5, 1, 5'd5, 0);
        // R5: write to index 31 discarded; R4: index 31 reads zero
        step("R5 write31", 0, 1, 5'd31, 1, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, 1, 5'd31, 0);
        step("R5 after", 0, 0, 0, 1, 0, 5'd5, 1, 5'd6, 1);
        // R9: enable low ignored
        step("R9 wr_en low", 0, 0, 5'd6, 1, 64'h1111_2222_3333_4444, 5'd6, 1, 5'd5, 1);
        step("R9 after", 0, 0, 0, 1, 0, 5'd6, 1, 5'd5, 1);
        // R6: bypass with half write seen on a full port and a half port
        step("R6 bypass", 0, 1, 5'd9, 0, 64'hCAFE_F00D_8765_4321, 5'd9, 1, 5'd9, 0);
        step("R6 bypass", 0, 1, 5'd9, 1, 64'hCAFE_F00D_8765_4321, 5'd9, 1, 5'd9, 0);
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic        we, ww, aw, bw;
            logic [4:0]  wi, ai, bi;
            logic [63:0] wd;
            we = $urandom % 4 != 0; ww = $urandom % 2; aw = $urandom % 2; bw = $urandom % 2;
            wi = 5'($urandom % 32); wd = {$urandom, $urandom};
            ai = ($urandom % 4 == 0) ? wi : 5'($urandom % 32);
            bi = 5'($urandom % 32);
            step((ai == 5'd31) ? "R4 rand" : (we && ai == wi) ? "R6 rand" : !aw ? "R2 rand" : "R1 rand",
                 ($urandom % 500) == 0, we, wi, ww, wd, ai, aw, bi, bw);
        end
        // R7: reset clears every entry
        step("R7 reset all", 1, 0, 0, 1, 0, 0, 1, 0, 1);
        for (int i = 0; i < 31; i += 2)
            step("R7 cleared", 0, 0, 0, 1, 0, 5'(i), 1, 5'((i + 1) % 31), 1);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule